// File: doc/BRIEF.md
# GPIO Port with Alternate-Function Steering

This block manages an eight-pin general-purpose I/O port. A small synchronous register bus holds four writable control registers and one read-only register. The control registers are per-pin mode select, direction, output data and weak pull-up enable. The read-only register reports the pin levels. Each pin is steered one of two ways. In port mode its pad is driven from the direction and output-data registers. In peripheral mode an attached peripheral supplies the output value and output enable.

Toward the pad models, the block produces per-pin output-enable, output-value, input-buffer-enable and pull-up-enable signals. The input-buffer enable is not a plain register bit. In port mode it opens only while the pin-level register is being read, and in peripheral mode it is always open. The pull-up enable is also qualified rather than stored. It depends on the pin mode, on whether the output driver is off and, in peripheral mode, on the peripheral's input or bidirectional flag. Pin levels pass through a two-stage synchronizer before they reach the read path. Reads return their data on the cycle after the read strobe.

Top module: `gpio_altmux_port`

## Requirements
- R1: After reset, the mode, direction, output-data and pull-up registers are all zero, pad_oe and pad_pu are all zero, and bus_rdata is zero.
- R2: Register addresses are: 0 mode select (1 = peripheral mode), 1 direction (1 = output), 2 output data, 3 pin levels (read-only), 4 pull-up enable. A write to address 3 changes nothing. A read of address 5, 6 or 7 returns zero.
- R3: For a pin in port mode, pad_oe equals its direction bit and pad_out equals its output-data bit.
- R4: For a pin in peripheral mode, pad_oe equals alt_oe and pad_out equals alt_out for that pin.
- R5: For a pin in peripheral mode, pad_ie is 1. For a pin in port mode, pad_ie is 1 only while bus_rd is high with bus_addr equal to 3, and 0 otherwise.
- R6: For a pin in port mode, pad_pu is 1 exactly when its pull-up bit is 1 and its direction bit is 0.
- R7: For a pin in peripheral mode, pad_pu is 1 exactly when its pull-up bit is 1, alt_in is 1 and alt_oe is 0. pad_pu and pad_oe are never both 1 on the same pin.
- R8: A read of address 3 returns pin_in as it was sampled through two flip-flop stages. A pin change made just before a read strobe is not yet visible in that read, but it is visible in a read made two cycles later. A read of address 2 returns the last written value, whatever the pin levels are.
- R9: bus_rdata is updated on the clock edge where bus_rd is high and holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pin_in | input | 8 | Pin levels from the pads |
| alt_out | input | 8 | Peripheral output value per pin |
| alt_oe | input | 8 | Peripheral output enable per pin |
| alt_in | input | 8 | Peripheral pin acts as input or bidirectional |
| pad_oe | output | 8 | Pad output-driver enable |
| pad_out | output | 8 | Pad output value |
| pad_ie | output | 8 | Pad input-buffer enable |
| pad_pu | output | 8 | Pad weak pull-up enable |

## Verification
The bench mixes port-mode and peripheral-mode pins in one configuration. A steering mux that selects per port instead of per pin would therefore drive the wrong output enable, value or pull-up on some bits. It checks that the input buffer opens in port mode only while the pin-level register is read. A design that left it open, or opened it for any read address, would fail that check. It writes to the read-only address and then checks both the control registers and the pin-level readback. A design that decoded that write would corrupt one of them. It also measures the synchronizer latency by reading right after a pin change and again two cycles later. A design with one stage, or with none, would show the new level too early.

// File: rtl/gpio_altmux_port.sv
module gpio_altmux_port #(
  parameter int NPINS = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] alt_out,
  input  logic [NPINS-1:0] alt_oe,
  input  logic [NPINS-1:0] alt_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_ie,
  output logic [NPINS-1:0] pad_pu
);

  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_DOUT = AW'(2);
  localparam logic [AW-1:0] A_LVL  = AW'(3);
  localparam logic [AW-1:0] A_PU   = AW'(4);

  logic [NPINS-1:0] mode_q, dir_q, dout_q, pu_q;
  logic [NPINS-1:0] sync1_q, sync2_q;
  logic [NPINS-1:0] rd_mux;
  logic             lvl_read;

  assign lvl_read = bus_rd && (bus_addr == A_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      pu_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE:  mode_q <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_DOUT:  dout_q <= bus_wdata;
        A_PU:    pu_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  rd_mux = mode_q;
      A_DIR:   rd_mux = dir_q;
      A_DOUT:  rd_mux = dout_q;
      A_LVL:   rd_mux = sync2_q;
      A_PU:    rd_mux = pu_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic drv_en;
    assign drv_en     = mode_q[i] ? alt_oe[i] : dir_q[i];
    assign pad_oe[i]  = drv_en;
    assign pad_out[i] = mode_q[i] ? alt_out[i] : dout_q[i];
    assign pad_ie[i]  = mode_q[i] | lvl_read;
    assign pad_pu[i]  = pu_q[i] & ~drv_en & (~mode_q[i] | alt_in[i]);
  end

endmodule

// File: rtl/gpio_altmux_port_chk.sv
module gpio_altmux_port_chk #(
  parameter int NPINS = 8,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] mode_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] dout_q,
  input logic [NPINS-1:0] pu_q,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_ie,
  input logic [NPINS-1:0] pad_pu
);

  a_r2_lvl_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3)) |=>
      ($stable(mode_q) && $stable(dir_q) && $stable(dout_q) && $stable(pu_q)));

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > AW'(4)) |=> (bus_rdata == '0));

  a_r5_ie_closed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == AW'(3)) |-> ((pad_ie & ~mode_q) == '0));

  a_r5_ie_open_alt: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q & ~pad_ie) == '0));

  a_r7_pu_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_oe) == '0));

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_altmux_port gpio_altmux_port_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .mode_q(mode_q), .dir_q(dir_q), .dout_q(dout_q), .pu_q(pu_q),
  .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_pu(pad_pu)
);

// File: tb/gpio_altmux_port_bench.sv
module gpio_altmux_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_in = '0, alt_out = '0, alt_oe = '0, alt_in = '0;
  logic [7:0] pad_oe, pad_out, pad_ie, pad_pu;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_altmux_port u_gpio_altmux_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .alt_out(alt_out),
    .alt_oe(alt_oe), .alt_in(alt_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_ie(pad_ie), .pad_pu(pad_pu)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    for (int a = 0; a < 5; a++) begin
      if (a != 3) begin
        rd(3'(a), v);
        check("R1 register", v, 8'h00);
      end
    end
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(3'd1, 8'h5A); rd(3'd1, v); check("R2 dir", v, 8'h5A);
    wr(3'd2, 8'hC3); rd(3'd2, v); check("R2 dout", v, 8'hC3);
    wr(3'd4, 8'h0F); rd(3'd4, v); check("R2 pullup", v, 8'h0F);
    pin_in = 8'h33;
    repeat (3) @(negedge clk);
    wr(3'd3, 8'hCC);
    rd(3'd3, v); check("R2 level write ignored", v, 8'h33);
    rd(3'd1, v); check("R2 dir after level write", v, 8'h5A);
    rd(3'd0, v); check("R2 mode after level write", v, 8'h00);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); check("R2 unmapped", v, 8'h00);
    end
  endtask

  task automatic t_gpio;
    logic [7:0] v;
    wr(3'd0, 8'h00); wr(3'd1, 8'hF0); wr(3'd2, 8'hA5); wr(3'd4, 8'hFF);
    pin_in = 8'h00;
    @(negedge clk);
    check("R3 pad_oe", pad_oe, 8'hF0);
    check("R3 pad_out", pad_out, 8'hA5);
    check("R6 pad_pu", pad_pu, 8'h0F);
    rd(3'd2, v); check("R8 dout readback", v, 8'hA5);
  endtask

  task automatic t_ie;
    @(negedge clk);
    check("R5 idle ie", pad_ie, 8'h00);
    bus_addr = 3'd3; bus_rd = 1'b1; #1;
    check("R5 ie during level read", pad_ie, 8'hFF);
    bus_addr = 3'd2; #1;
    check("R5 ie during other read", pad_ie, 8'h00);
    @(negedge clk); bus_rd = 1'b0;
    wr(3'd0, 8'h81);
    check("R5 ie peripheral pins", pad_ie, 8'h81);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_alt;
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd4, 8'hFF);
    alt_out = 8'hFF; alt_oe = 8'h03; alt_in = 8'h05;
    wr(3'd0, 8'h0F);
    check("R4 pad_oe mixed", pad_oe, 8'h03);
    check("R4 pad_out mixed", pad_out, 8'h0F);
    check("R7 pad_pu mixed", pad_pu, 8'hF4);
    alt_oe = 8'h00; alt_in = 8'h00; #1;
    check("R7 pad_pu no input flag", pad_pu, 8'hF0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    pin_in = 8'h96;
    rd(3'd3, v); check("R8 sync too early", v, 8'h00);
    rd(3'd3, v); check("R8 sync settled", v, 8'h96);
    wr(3'd2, 8'h3C);
    rd(3'd2, v); check("R8 dout not pin", v, 8'h3C);
    repeat (3) @(negedge clk);
    check("R9 rdata hold", bus_rdata, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gpio();
    t_ie();
    t_alt();
    t_sync();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule